// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block produces two independent pulse-width modulated outputs. Software reaches it through a small register bus with one write strobe and a read port with no wait states. A single control word carries the settings of both channels, and each channel also has its own timing word. Each channel first divides the system clock by a ratio taken from a fixed table. It then counts prescaled ticks through a programmable period and holds its output at the active level for a programmable number of those ticks.

The two halves of a timing word are the active (duty) count and the period length minus one. A write to a timing word goes into a shadow copy. The running channel picks up that copy only when its current period ends, so no period is ever cut short. Until the pick-up happens, a read-only busy flag for that channel stays set in the control word. Each channel has a polarity bit, an enable bit and a clock-gate bit. The gate bit freezes the counter while software changes the prescaler. Table codes that have no ratio also freeze the channel.

Top module: `pwm2ch`

## Requirements
- R1: The control word is at address 0x0 and the timing word of channel n is at 0x4 + 4·n. Channel n's 10-bit field sits at control bits [15·n+9 : 15·n]. Within a field: bits 3:0 are the prescaler code, bit 4 enables, bit 5 sets the active level, bit 6 opens the clock gate, and bits 7 to 9 (mode, pulse, bypass) are stored and read back. A timing word reads back the value last written to it.
- R2: In a timing word, bits 15:0 are the duty count D and bits 31:16 are the period field F. An enabled channel repeats a cycle of F+1 prescaled ticks and is active for the first D of them.
- R3: The prescaler codes 0,1,2,3,4 divide by 120,180,240,360,480. Codes 8 to 12 divide by 12000,24000,36000,48000,72000. Code 15 divides by 1.
- R4: The reserved prescaler codes 5, 6, 7, 13 and 14 stop the channel counter, so the output holds its level.
- R5: While the gate bit is 0, the counter of an enabled channel does not advance, and the output holds its level.
- R6: With the active-level bit at 1, the active level is 1 and the inactive level is 0. With the bit at 0, both levels are inverted.
- R7: A disabled channel keeps its counter at 0 and drives its inactive level.
- R8: D = 0 gives a constant inactive output. D > F gives a constant active output.
- R9: A timing write is held in the shadow copy. An enabled channel takes it at the end of its current period. A disabled channel takes it on the next clock.
- R10: Control bit 28+n reads 1 from the clock after a write to channel n's timing word until that value is taken. Writes to bits 28 and 29 are ignored.
- R11: After reset every register is 0, all reads return 0 and both outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | Channel outputs |

## Verification
The duty output is measured by counting high cycles over a window that is a whole number of periods. That count does not depend on the phase, and it separates a wrong duty, a wrong period and an off-by-one in either. The same measurement is repeated on both channels with different timing, with inverted polarity, and with D = 0 and D > F. This rules out a shared counter and a wrong comparison at the ends of the range. Three table codes are run with a two-tick period, and the expected counts tell one ratio from another. The freeze cases are a closed gate, a reserved code and a disabled channel. With the gate closed, the busy flag stays set for hundreds of cycles and clears only after the gate opens, which shows that the shadow is taken at the period boundary and not at the time of the write.

// File: rtl/pwm2ch.sv
module pwm2ch #(
  parameter int NCH = 2,
  parameter int AW  = 4,
  parameter int PSW = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CW     = 16;
  localparam int FLD    = 10;
  localparam int STRIDE = 15;
  localparam int RDYB   = 28;

  function automatic logic [PSW-1:0] div_ratio(input logic [3:0] code);
    case (code)
      4'd0:  div_ratio = PSW'(120);
      4'd1:  div_ratio = PSW'(180);
      4'd2:  div_ratio = PSW'(240);
      4'd3:  div_ratio = PSW'(360);
      4'd4:  div_ratio = PSW'(480);
      4'd8:  div_ratio = PSW'(12000);
      4'd9:  div_ratio = PSW'(24000);
      4'd10: div_ratio = PSW'(36000);
      4'd11: div_ratio = PSW'(48000);
      4'd12: div_ratio = PSW'(72000);
      4'd15: div_ratio = PSW'(1);
      default: div_ratio = '0;
    endcase
  endfunction

  logic [NCH-1:0][FLD-1:0] fld_all;
  logic [NCH-1:0][31:0]    shd_all;
  logic [NCH-1:0][31:0]    wrk_all;
  logic [NCH-1:0][CW-1:0]  cnt_all;
  logic [NCH-1:0]          pend_all;

  wire ctrl_wr = bus_we && bus_addr == '0;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [FLD-1:0] fld;
    logic [31:0]    shd, wrk;
    logic [CW-1:0]  cnt;
    logic [PSW-1:0] pcnt;
    logic           pend;

    wire [PSW-1:0] ratio = div_ratio(fld[3:0]);
    wire en    = fld[4];
    wire act   = fld[5];
    wire run   = en && fld[6] && ratio != '0;
    wire tick  = run && pcnt >= ratio - PSW'(1);
    wire wrap  = tick && cnt == wrk[16 +: CW];
    wire tw    = bus_we && bus_addr == AW'(4 * ch + 4);
    wire take  = pend && (wrap || !en);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld  <= '0;
        shd  <= '0;
        wrk  <= '0;
        cnt  <= '0;
        pcnt <= '0;
        pend <= 1'b0;
      end else begin
        if (ctrl_wr) fld <= bus_wdata[ch*STRIDE +: FLD];
        if (tw) shd <= bus_wdata;
        if (tw) pend <= 1'b1;
        else if (take) pend <= 1'b0;
        if (take) wrk <= shd;
        if (!en) pcnt <= '0;
        else if (run) pcnt <= tick ? '0 : pcnt + PSW'(1);
        if (!en) cnt <= '0;
        else if (tick) cnt <= wrap ? '0 : cnt + CW'(1);
      end
    end

    assign pwm_out[ch]  = (en && cnt < wrk[CW-1:0]) ? act : ~act;
    assign fld_all[ch]  = fld;
    assign shd_all[ch]  = shd;
    assign wrk_all[ch]  = wrk;
    assign cnt_all[ch]  = cnt;
    assign pend_all[ch] = pend;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bus_rdata[ch*STRIDE +: FLD] = fld_all[ch];
        bus_rdata[RDYB + ch]        = pend_all[ch];
      end
    end
    for (int ch = 0; ch < NCH; ch++)
      if (bus_addr == AW'(4 * ch + 4)) bus_rdata = shd_all[ch];
  end
endmodule

// File: rtl/pwm2ch_chk.sv
module pwm2ch_chk #(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_we,
  input logic [AW-1:0]        bus_addr,
  input logic [NCH-1:0][9:0]  fld,
  input logic [NCH-1:0][31:0] wrk,
  input logic [NCH-1:0][15:0] cnt,
  input logic [NCH-1:0]       pend
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_a
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !fld[ch][4] |=> cnt[ch] == '0); // R7
    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      fld[ch][4] && !fld[ch][6] |=> cnt[ch] == $past(cnt[ch])); // R5
    AST_RSV_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      fld[ch][4] && fld[ch][3:0] inside {4'd5, 4'd6, 4'd7, 4'd13, 4'd14}
      |=> cnt[ch] == $past(cnt[ch])); // R4
    AST_TAKE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[ch]) |-> cnt[ch] == '0); // R9
    AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == AW'(4 * ch + 4) |=> pend[ch]); // R10
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[ch] <= wrk[ch][31:16]); // R2
  end
endmodule

bind pwm2ch pwm2ch_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .fld(fld_all), .wrk(wrk_all), .cnt(cnt_all), .pend(pend_all)
);

// File: tb/tb_pwm2ch.sv
module tb_pwm2ch;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] pout;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pwm2ch dut (.clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
              .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pout));

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic high_count(int ch, int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pout[ch]) c++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R11 ctrl", d, 0);
    rd(4'h4, d); chk("R11 tw0", d, 0);
    rd(4'h8, d); chk("R11 tw1", d, 0);
    chk("R11 R6 outputs", pout, 2'b11);
  endtask

  task automatic t_basic;
    int c; logic [31:0] d;
    wr(4'h4, (32'd4 << 16) | 32'd2);
    wr(4'h8, (32'd7 << 16) | 32'd3);
    repeat (3) @(negedge clk);
    rd(4'h0, d); chk("R10 busy clears when disabled", d[29:28], 0);
    rd(4'h4, d); chk("R1 tw0 readback", d, (32'd4 << 16) | 32'd2);
    wr(4'h0, 32'h7F | (32'h7F << 15));
    repeat (20) @(negedge clk);
    high_count(0, 50, c); chk("R2 ch0 duty 2/5", c, 20);
    high_count(1, 80, c); chk("R2 ch1 duty 3/8", c, 30);
  endtask

  task automatic t_duty_edges;
    int c;
    wr(4'h4, (32'd4 << 16) | 32'd0);
    repeat (20) @(negedge clk);
    high_count(0, 50, c); chk("R8 duty zero", c, 0);
    wr(4'h4, (32'd4 << 16) | 32'd9);
    repeat (20) @(negedge clk);
    high_count(0, 50, c); chk("R8 duty above period", c, 50);
  endtask

  task automatic t_polarity;
    int c;
    wr(4'h4, (32'd4 << 16) | 32'd2);
    wr(4'h0, 32'h5F | (32'h7F << 15));
    repeat (20) @(negedge clk);
    high_count(0, 50, c); chk("R6 inverted level", c, 30);
  endtask

  task automatic t_shadow;
    int c, n; logic [31:0] d;
    wr(4'h0, 32'h0);
    wr(4'h4, (32'd99 << 16) | 32'd10);
    wr(4'h0, 32'h3F);
    wr(4'h4, (32'd49 << 16) | 32'd5);
    rd(4'h0, d); chk("R10 busy set on write", d[28], 1);
    chk("R10 other channel idle", d[29], 0);
    high_count(0, 300, c);
    rd(4'h0, d); chk("R9 held while gate closed", d[28], 1);
    chk("R5 gate closed output steady", (c == 0 || c == 300), 1);
    wr(4'h0, 32'h7F | (32'h3 << 28));
    n = 0;
    rd(4'h0, d);
    while (d[28] && n < 400) begin @(negedge clk); n++; rd(4'h0, d); end
    chk("R9 taken within one period", (n <= 102), 1);
    rd(4'h0, d); chk("R10 busy bits not writable", d, 32'h7F);
    high_count(0, 250, c); chk("R9 new timing in use", c, 25);
  endtask

  task automatic t_prescale;
    int c;
    wr(4'h0, 32'h0);
    wr(4'h4, (32'd1 << 16) | 32'd1);
    wr(4'h0, 32'h70);
    repeat (300) @(negedge clk);
    high_count(0, 480, c); chk("R3 code0 /120", c, 240);
    wr(4'h0, 32'h71);
    repeat (800) @(negedge clk);
    high_count(0, 720, c); chk("R3 code1 /180", c, 360);
    wr(4'h0, 32'h74);
    repeat (1200) @(negedge clk);
    high_count(0, 960, c); chk("R3 code4 /480", c, 480);
  endtask

  task automatic t_reserved;
    int c;
    wr(4'h0, 32'h0);
    wr(4'h4, (32'd4 << 16) | 32'd2);
    wr(4'h0, 32'h7F);
    repeat (7) @(negedge clk);
    wr(4'h0, 32'h75);
    high_count(0, 100, c); chk("R4 reserved code holds", (c == 0 || c == 100), 1);
    wr(4'h0, 32'h7D);
    high_count(0, 100, c); chk("R4 code13 holds", (c == 0 || c == 100), 1);
  endtask

  task automatic t_disable;
    int c; logic [31:0] d;
    wr(4'h0, 32'h60 | (32'h7F << 15));
    repeat (20) @(negedge clk);
    chk("R7 disabled active-high idle", pout[0], 0);
    high_count(1, 80, c); chk("R7 other channel runs", c, 30);
    wr(4'h0, 32'h40 | ((32'h380 | 32'h7F) << 15));
    @(negedge clk);
    chk("R7 disabled inverted idle", pout[0], 1);
    rd(4'h0, d); chk("R1 mode bits stored", d, 32'h40 | (32'h3FF << 15));
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3; t_reset;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_duty_edges;
    t_polarity;
    t_shadow;
    t_prescale;
    t_reserved;
    t_disable;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule